// File: doc/BRIEF.md
# Descriptor Ring Ownership Controller

This block services a circular list of work descriptors in shared memory for a data-processing engine. Software places descriptors in a packet ring, marks each one as belonging to the hardware by setting its ownership flag, and then writes the poll register. The controller reads the descriptor at its current ring position. If the flag is set, it passes the descriptor to the engine through a start/done handshake. It then writes a result word into a second ring and, unless told otherwise, writes the descriptor back with the flag cleared so that the entry is not taken a second time after the index wraps. When it reads a descriptor that software has not handed over, it stops and waits for the next poll.

A configuration bit lets software take over the clearing itself, which saves one memory write per descriptor. The hardware ignores that bit whenever the two rings share any address, because the result write could otherwise leave stale owned entries behind. Memory is reached through a single-word request/acknowledge port with at most one transaction in flight. The engine's own processing is outside this block.

Top module: `desc_ring_ctl`

## Requirements
- R1: After reset the controller is idle, the status register (byte offset 0x44) reads zero, the configuration register (0x40) reads 0x0010_0000 (skip-writeback bit 20 set), and no memory request or engine start is active.
- R2: A write of any value to the poll register (0x54) while idle starts a read of the descriptor word at packet-ring base + index × DESC_BYTES.
- R3: A fetched descriptor whose ownership flag (bit 31) is 0 returns the controller to idle with no engine start and no write; it issues no further memory request until the next poll write.
- R4: A fetched descriptor with bit 31 set produces a single-cycle `eng_start` with `eng_desc` equal to the fetched word, and the controller waits for `eng_done` before any write.
- R5: After every completed descriptor, the fetched word with bit 31 cleared is written to result-ring base + index × DESC_BYTES, whatever the skip-writeback setting.
- R6: With skip-writeback (configuration bit 20) at 0, the result write is followed by a write of the same cleared word to the descriptor's packet-ring address.
- R7: With skip-writeback at 1 and disjoint rings, no write goes to the packet ring, so each descriptor costs exactly one write.
- R8: The rings overlap when [pkt_base, pkt_base + n × DESC_BYTES) and [res_base, res_base + n × DESC_BYTES) intersect, n being the ring size with 0 read as 1; when they overlap, the packet-ring writeback happens even with skip-writeback at 1.
- R9: After each completed descriptor the index increments and wraps to 0 after entry n − 1; status bit 31 is busy, the index sits at bits 16 upward and the completed-descriptor count (modulo 2^16) at bits 15:0.
- R10: Each memory request stays asserted with stable address, direction and write data until `mem_ack`, and only one is outstanding at a time.
- R11: Packet-ring base (0x48), result-ring base (0x4C) and ring size (0x50) read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| eng_start | output | 1 | One-cycle pulse handing a descriptor to the engine |
| eng_desc | output | 32 | Descriptor word for the engine |
| eng_done | input | 1 | Engine completion |

## Verification
The bench builds the block with 8-byte descriptor spacing and a 4-bit index. Ring sizes from 0 through 15 therefore fit inside a 1 KB memory model, and the wrap at the top of the index range, the size-0 case and partially overlapping rings all come up often under random bases. With random memory and engine latencies, result writes into an overlapping packet ring clear descriptors before the controller reaches them. A bench model replays the same order of reads and writes to predict the final memory image, the write count and the index.

// File: rtl/drc_pkg.sv
package drc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_FETCH   = 3'd1,
      ST_CHECK   = 3'd2,
      ST_PROCESS = 3'd3,
      ST_WRES    = 3'd4,
      ST_CLEAR   = 3'd5,
      ST_ADV     = 3'd6
   } drc_state_e;

   localparam logic [7:0] RA_CFG   = 8'h40;
   localparam logic [7:0] RA_STAT  = 8'h44;
   localparam logic [7:0] RA_PBASE = 8'h48;
   localparam logic [7:0] RA_RBASE = 8'h4C;
   localparam logic [7:0] RA_SIZE  = 8'h50;
   localparam logic [7:0] RA_POLL  = 8'h54;

   localparam int CFG_SKIP_BIT = 20;
   localparam int STAT_BUSY_BIT = 31;
   localparam int STAT_IDX_LSB = 16;

endpackage

// File: rtl/drc_regs.sv
module drc_regs
   import drc_pkg::*;
#(
   parameter int AW    = 32,
   parameter int IDX_W = 8,
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   input  logic             busy,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic [CNT_W-1:0] done_cnt,
   output logic [31:0]      reg_rdata,
   output logic             skip_wb,
   output logic [AW-1:0]    pkt_base,
   output logic [AW-1:0]    res_base,
   output logic [IDX_W-1:0] ring_size,
   output logic             poll
);

   logic [31:0] stat_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_wb   <= 1'b1;
         pkt_base  <= '0;
         res_base  <= '0;
         ring_size <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_CFG:   skip_wb   <= reg_wdata[CFG_SKIP_BIT];
            RA_PBASE: pkt_base  <= reg_wdata[AW-1:0];
            RA_RBASE: res_base  <= reg_wdata[AW-1:0];
            RA_SIZE:  ring_size <= reg_wdata[IDX_W-1:0];
            default:  ;
         endcase
      end
   end

   assign poll = reg_wr && (reg_addr == RA_POLL);

   always_comb begin
      stat_word = '0;
      stat_word[STAT_BUSY_BIT] = busy;
      stat_word[STAT_IDX_LSB +: IDX_W] = cur_idx;
      stat_word[CNT_W-1:0] = done_cnt;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CFG:   reg_rdata[CFG_SKIP_BIT] = skip_wb;
         RA_STAT:  reg_rdata = stat_word;
         RA_PBASE: reg_rdata[AW-1:0] = pkt_base;
         RA_RBASE: reg_rdata[AW-1:0] = res_base;
         RA_SIZE:  reg_rdata[IDX_W-1:0] = ring_size;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/drc_overlap.sv
module drc_overlap #(
   parameter int AW         = 32,
   parameter int IDX_W      = 8,
   parameter int DESC_BYTES = 8,
   parameter bit DETECT     = 1'b1
)(
   input  logic [AW-1:0]    pkt_base,
   input  logic [AW-1:0]    res_base,
   input  logic [IDX_W-1:0] ring_size,
   output logic             overlap
);

   localparam int SH = $clog2(DESC_BYTES);
   localparam int EW = AW + IDX_W + SH + 1;

   generate
      if (DETECT) begin : g_cmp
         logic [IDX_W:0] n_eff;
         logic [EW-1:0]  span;
         logic [EW-1:0]  p_lo, p_hi, r_lo, r_hi;

         always_comb begin
            n_eff = (ring_size == '0) ? {{IDX_W{1'b0}}, 1'b1} : {1'b0, ring_size};
            span  = EW'(n_eff) << SH;
            p_lo  = EW'(pkt_base);
            r_lo  = EW'(res_base);
            p_hi  = p_lo + span;
            r_hi  = r_lo + span;
         end

         assign overlap = (p_lo < r_hi) && (r_lo < p_hi);

         // R8: identical bases always count as overlapping
         always_comb begin
            if (rst_check_en(pkt_base, res_base))
               p_same_base_r8: assert (overlap);
         end

         function automatic logic rst_check_en(input logic [AW-1:0] a, input logic [AW-1:0] b);
            return (a == b);
         endfunction
      end else begin : g_off
         assign overlap = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/drc_seq.sv
module drc_seq
   import drc_pkg::*;
#(
   parameter int AW         = 32,
   parameter int IDX_W      = 8,
   parameter int CNT_W      = 16,
   parameter int DESC_BYTES = 8,
   parameter int OWN_BIT    = 31
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poll,
   input  logic             need_clear,
   input  logic [AW-1:0]    pkt_base,
   input  logic [AW-1:0]    res_base,
   input  logic [IDX_W-1:0] ring_size,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata,
   output logic             eng_start,
   output logic [31:0]      eng_desc,
   input  logic             eng_done,
   output logic             busy,
   output logic [IDX_W-1:0] cur_idx,
   output logic [CNT_W-1:0] done_cnt
);

   localparam int SH = $clog2(DESC_BYTES);
   localparam logic [31:0] OWN_MASK = 32'd1 << OWN_BIT;

   drc_state_e       state_q, state_d;
   logic [31:0]      desc_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic [AW-1:0]    ring_ofs;
   logic [IDX_W-1:0] last_idx;
   logic             at_last;
   logic             owned;

   assign ring_ofs = AW'(idx_q) << SH;
   assign last_idx = (ring_size == '0) ? '0 : ring_size - IDX_W'(1);
   assign at_last  = (idx_q >= last_idx);
   assign owned    = desc_q[OWN_BIT];

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:    if (poll) state_d = ST_FETCH;
         ST_FETCH:   if (mem_ack) state_d = ST_CHECK;
         ST_CHECK:   state_d = owned ? ST_PROCESS : ST_IDLE;
         ST_PROCESS: if (eng_done) state_d = ST_WRES;
         ST_WRES:    if (mem_ack) state_d = need_clear ? ST_CLEAR : ST_ADV;
         ST_CLEAR:   if (mem_ack) state_d = ST_ADV;
         ST_ADV:     state_d = ST_FETCH;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         desc_q  <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_FETCH && mem_ack)
            desc_q <= mem_rdata;
         if (state_q == ST_ADV) begin
            idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_WRES) || (state_q == ST_CLEAR);
   assign mem_we    = (state_q == ST_WRES) || (state_q == ST_CLEAR);
   assign mem_addr  = ((state_q == ST_WRES) ? res_base : pkt_base) + ring_ofs;
   assign mem_wdata = desc_q & ~OWN_MASK;
   assign eng_start = (state_q == ST_CHECK) && owned;
   assign eng_desc  = desc_q;
   assign busy      = (state_q != ST_IDLE);
   assign cur_idx   = idx_q;
   assign done_cnt  = cnt_q;

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   p_no_write_while_engine_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PROCESS) |-> !mem_req);

   p_idle_until_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !poll) |=> (state_q == ST_IDLE && !mem_req));

   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADV && at_last) |=> (cur_idx == '0));

   p_clear_after_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CLEAR) |-> ($past(state_q) == ST_WRES || $past(state_q) == ST_CLEAR));

   p_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRES && mem_ack && need_clear) |=> (mem_req && mem_we));

   p_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRES && mem_ack && !need_clear) |=> !mem_req);

endmodule

// File: rtl/desc_ring_ctl.sv
module desc_ring_ctl
   import drc_pkg::*;
#(
   parameter int IDX_W          = 8,
   parameter int CNT_W          = 16,
   parameter int DESC_BYTES     = 8,
   parameter int OWN_BIT        = 31,
   parameter bit OVERLAP_DETECT = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [7:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic        eng_start,
   output logic [31:0] eng_desc,
   input  logic        eng_done
);

   localparam int AW = 32;

   generate
      if (DESC_BYTES < 4 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_stride
         $error("DESC_BYTES must be a power of two of at least 4");
      end
      if (IDX_W < 1 || IDX_W > 15) begin : g_bad_idx
         $error("IDX_W must lie in 1..15 to fit the status word");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16 to fit the status word");
      end
      if (OWN_BIT < 0 || OWN_BIT > 31) begin : g_bad_own
         $error("OWN_BIT must select a bit of the descriptor word");
      end
   endgenerate

   logic             skip_wb;
   logic [AW-1:0]    pkt_base;
   logic [AW-1:0]    res_base;
   logic [IDX_W-1:0] ring_size;
   logic             poll;
   logic             overlap;
   logic             need_clear;
   logic             busy;
   logic [IDX_W-1:0] cur_idx;
   logic [CNT_W-1:0] done_cnt;

   drc_regs #(.AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .busy      (busy),
      .cur_idx   (cur_idx),
      .done_cnt  (done_cnt),
      .reg_rdata (reg_rdata),
      .skip_wb   (skip_wb),
      .pkt_base  (pkt_base),
      .res_base  (res_base),
      .ring_size (ring_size),
      .poll      (poll)
   );

   drc_overlap #(.AW(AW), .IDX_W(IDX_W), .DESC_BYTES(DESC_BYTES), .DETECT(OVERLAP_DETECT)) u_ovl (
      .pkt_base  (pkt_base),
      .res_base  (res_base),
      .ring_size (ring_size),
      .overlap   (overlap)
   );

   assign need_clear = !skip_wb || overlap;

   drc_seq #(
      .AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES), .OWN_BIT(OWN_BIT)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .poll       (poll),
      .need_clear (need_clear),
      .pkt_base   (pkt_base),
      .res_base   (res_base),
      .ring_size  (ring_size),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .eng_start  (eng_start),
      .eng_desc   (eng_desc),
      .eng_done   (eng_done),
      .busy       (busy),
      .cur_idx    (cur_idx),
      .done_cnt   (done_cnt)
   );

   // R8: with overlapping rings the packet-ring writeback is never skipped
   p_overlap_forces_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overlap |-> need_clear);

endmodule

// File: tb/desc_ring_ctl_test.sv
`timescale 1ns/1ps
module desc_ring_ctl_test;

   localparam int DB = 8;
   localparam int IW = 4;
   localparam logic [7:0] A_CFG = 8'h40, A_STAT = 8'h44, A_PB = 8'h48,
                          A_RB = 8'h4C, A_SZ = 8'h50, A_POLL = 8'h54;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = 32'h0;
   logic        eng_start;
   logic [31:0] eng_desc;
   logic        eng_done = 1'b0;

   always #2 clk = ~clk;

   desc_ring_ctl #(.IDX_W(IW), .DESC_BYTES(DB)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .eng_start(eng_start),
      .eng_desc(eng_desc), .eng_done(eng_done)
   );

   bit [31:0] mem [256];
   bit [31:0] ref_mem [256];
   int checks = 0, errors = 0;
   int mchk = 0, merr = 0, echk = 0, eerr = 0, wd_err = 0;
   int n_reads = 0, n_writes = 0, n_starts = 0;
   logic [31:0] rd_log [64];
   logic [31:0] last_rd_addr = 32'h0, last_rd_data = 32'h0;
   logic        ld_en = 1'b0;
   logic [7:0]  ld_addr = 8'h0;
   logic [31:0] ld_data = 32'h0;
   logic        hc_en = 1'b0;
   logic        hc_pulse = 1'b0;
   logic [7:0]  hc_word = 8'h0;
   int exp_idx = 0, exp_cnt = 0;

   // memory model, random 0..2 wait cycles
   bit pend = 0; int dly = 0; logic [31:0] la, lw; logic lwe;
   always @(posedge clk) begin
      if (ld_en) mem[ld_addr] <= ld_data;
      if (hc_pulse) mem[hc_word][31] <= 1'b0;
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
         if (!pend) begin
            pend = 1; la = mem_addr; lwe = mem_we; lw = mem_wdata; dly = $urandom % 3;
         end else begin
            mchk++;
            if (mem_addr !== la || mem_we !== lwe || mem_wdata !== lw) begin
               merr++;
               $display("FAIL R10 request changed before ack: actual addr 0x%0h expected 0x%0h", mem_addr, la);
            end
         end
         if (dly == 0) begin
            pend = 0;
            mem_ack <= 1'b1;
            if (lwe) begin
               mem[la[9:2]] <= lw;
               n_writes++;
            end else begin
               mem_rdata <= mem[la[9:2]];
               last_rd_data <= mem[la[9:2]];
               last_rd_addr <= la;
               rd_log[n_reads % 64] = la;
               n_reads++;
            end
         end else dly--;
      end else if (pend) begin
         mchk++; merr++; pend = 0;
         $display("FAIL R10 request dropped before ack: actual 0 expected 1");
      end
   end

   // engine model: checks the handed descriptor, optionally acts as software clearing ownership
   bit ebusy = 0; int etimer = 0;
   always @(posedge clk) begin
      hc_pulse <= 1'b0;
      eng_done <= 1'b0;
      if (rst_n && eng_start) begin
         echk++; n_starts++;
         if (eng_desc !== last_rd_data) begin
            eerr++;
            $display("FAIL R4 engine descriptor: actual 0x%0h expected 0x%0h", eng_desc, last_rd_data);
         end
         if (hc_en) begin hc_pulse <= 1'b1; hc_word <= last_rd_addr[9:2]; end
         etimer = 1 + $urandom % 4; ebusy = 1;
      end else if (ebusy) begin
         if (etimer == 1) begin eng_done <= 1'b1; ebusy = 0; end
         else etimer--;
      end
   end

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks + mchk + echk + wd_err,
               errors + merr + eerr + wd_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      wd_err = 1;
      $display("FAIL watchdog: actual running expected finished");
      report();
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
      end
   endtask

   task automatic reg_write(logic [7:0] a, logic [31:0] d);
      @(posedge clk); #1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1; reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [7:0] a, output logic [31:0] d);
      @(posedge clk); #1; reg_addr = a;
      @(negedge clk); d = reg_rdata;
   endtask

   task automatic load(int word, logic [31:0] d);
      @(posedge clk); #1; ld_en = 1'b1; ld_addr = 8'(word); ld_data = d;
      @(posedge clk); #1; ld_en = 1'b0;
   endtask

   function automatic bit rings_overlap(int pb, int rb, int sz);
      int len = ((sz == 0) ? 1 : sz) * DB;
      return (pb < rb + len) && (rb < pb + len);
   endfunction

   // replays the walk on a copy of memory in the same order as the required behaviour
   task automatic model(int pb, int rb, int sz, bit skip, bit hc, output int n, output int nw);
      int eff = (sz == 0) ? 1 : sz;
      bit clr = !skip || rings_overlap(pb, rb, sz);
      for (int a = 0; a < 256; a++) ref_mem[a] = mem[a];
      n = 0; nw = 0;
      for (int k = 0; k < 200; k++) begin
         int pw = ((pb + exp_idx * DB) >> 2) & 255;
         bit [31:0] w = ref_mem[pw];
         if (!w[31]) break;
         if (hc) ref_mem[pw][31] = 1'b0;
         ref_mem[((rb + exp_idx * DB) >> 2) & 255] = w & 32'h7fff_ffff;
         nw++;
         if (clr) begin ref_mem[pw] = w & 32'h7fff_ffff; nw++; end
         n++;
         exp_idx = (exp_idx >= eff - 1) ? 0 : exp_idx + 1;
      end
   endtask

   task automatic run_case(string tag, int pb, int rb, int sz, bit skip, bit hc, int lvl);
      int eff = (sz == 0) ? 1 : sz;
      int n, nw, r0, w0, s0, start_idx, mism;
      logic [31:0] d;
      for (int i = 0; i < eff; i++)
         load(((pb + i * DB) >> 2) & 255,
              ((($urandom % 4) < lvl) ? 32'h8000_0000 : 32'h0) | ($urandom & 32'h00ff_ffff));
      reg_write(A_CFG, skip ? 32'h0010_0000 : 32'h0);
      reg_write(A_PB, 32'(pb));
      reg_write(A_RB, 32'(rb));
      reg_write(A_SZ, 32'(sz));
      hc_en = hc;
      start_idx = exp_idx;
      model(pb, rb, sz, skip, hc, n, nw);
      exp_cnt = exp_cnt + n;
      r0 = n_reads; w0 = n_writes; s0 = n_starts;
      reg_write(A_POLL, 32'h1);
      forever begin
         reg_read(A_STAT, d);
         if (!d[31]) break;
      end
      chk("R2", "first fetch address", rd_log[r0 % 64], 32'(pb + start_idx * DB));
      chk("R3", "fetches per walk", 32'(n_reads - r0), 32'(n + 1));
      chk("R4", "engine starts", 32'(n_starts - s0), 32'(n));
      chk(tag, "memory writes", 32'(n_writes - w0), 32'(nw));
      chk("R9", "status index", 32'(d[16 +: IW]), 32'(exp_idx));
      chk("R9", "status count", 32'(d[15:0]), 32'(exp_cnt & 16'hffff));
      mism = 0;
      for (int a = 0; a < 256; a++) if (mem[a] != ref_mem[a]) mism++;
      chk(tag, "memory image mismatches", 32'(mism), 32'h0);
   endtask

   initial begin
      logic [31:0] d;
      int rn, wn, seed;
      seed = $urandom(32'h5eed_0042);
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "mem_req after reset", 32'(mem_req), 32'h0);
      chk("R1", "eng_start after reset", 32'(eng_start), 32'h0);
      reg_read(A_STAT, d);  chk("R1", "status after reset", d, 32'h0);
      reg_read(A_CFG, d);   chk("R1", "config after reset", d, 32'h0010_0000);

      reg_write(A_PB, 32'h0000_0124);
      reg_write(A_RB, 32'h0000_03a8);
      reg_write(A_SZ, 32'h0000_0009);
      reg_read(A_PB, d); chk("R11", "packet base readback", d, 32'h0000_0124);
      reg_read(A_RB, d); chk("R11", "result base readback", d, 32'h0000_03a8);
      reg_read(A_SZ, d); chk("R11", "ring size readback", d, 32'h0000_0009);
      reg_write(A_CFG, 32'h0);
      reg_read(A_CFG, d); chk("R11", "config cleared readback", d, 32'h0);

      // nothing owned: idle at once, and idle stays idle without a poll (R3)
      run_case("R3", 32'h000, 32'h200, 4, 1'b0, 1'b0, 0);
      rn = n_reads; wn = n_writes;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R3", "reads while idle without poll", 32'(n_reads), 32'(rn));
      chk("R3", "writes while idle without poll", 32'(n_writes), 32'(wn));

      run_case("R6", 32'h000, 32'h200, 4, 1'b0, 1'b0, 4);
      run_case("R7", 32'h040, 32'h280, 6, 1'b1, 1'b1, 4);
      run_case("R8", 32'h080, 32'h090, 6, 1'b1, 1'b0, 4);
      run_case("R8", 32'h0c0, 32'h0b8, 3, 1'b1, 1'b0, 4);
      run_case("R9", 32'h100, 32'h300, 3, 1'b0, 1'b0, 4);
      run_case("R9", 32'h180, 32'h300, 0, 1'b0, 1'b0, 4);
      run_case("R9", 32'h000, 32'h200, 15, 1'b0, 1'b0, 4);

      for (int t = 0; t < 24; t++) begin
         int sz = $urandom % 16;
         int pb = ($urandom % 48) * 8;
         int rb = ($urandom % 64) * 8;
         bit skip = $urandom % 2;
         bit hc = skip | ($urandom % 2);
         run_case("R5", pb, rb, sz, skip, hc, 1 + $urandom % 4);
      end

      report();
   end

endmodule